// File: doc/BRIEF.md
# MDIO Management Master

This block is a register-controlled master for the two-wire PHY management bus: one management clock (MDC) and one bidirectional data line (MDIO). A host writes a small bank of 32-bit registers to choose the MDC rate and whether the 32-bit preamble is sent. It also sets the PHY and register addresses and the data to write. The host then issues a command, and the block shifts out a complete management frame, MSB first. For reads it captures the PHY's 16-bit reply.

Three commands exist: a single read, a single write, and a scan that reads one register over and over. Scan keeps the receive data current and turns bit 2 of each scanned value into a link-fail flag. A status flag marks scan data as not yet valid until the first scan frame has completed. The line side drives MDC, drives MDIO through an output enable, and samples MDIO through a separate input.

Top module: `mdio_master`

## Requirements
- R1: Register word index `addr_i`: 0 mode, 1 command, 2 address, 3 transmit data, 4 receive data (read-only), 5 status (read-only). After reset, mode reads 0x64, command, status and the other registers read 0, and MDIO is not driven.
- R2: Mode bits 7:0 are the MDC divider. The MDC period is 2*max(div[7:1],1) system clocks, so bit 0 of the divider has no effect.
- R3: Every frame starts with 32 MDIO ones, unless mode bit 8 is set. In that case the frame begins directly with the start bits.
- R4: A read or scan frame is start 01, opcode 10, then the PHY address from address bits 4:0, then the register address from address bits 12:8. The output enable drops for the two turnaround bits and the 16 data bits.
- R5: A write frame is start 01, opcode 01, the same two addresses, a driven turnaround of 10, and transmit data bits 15:0, MSB first, with the output enable held high throughout.
- R6: MDIO output and its enable change only when MDC falls. Read data is sampled when MDC rises and lands in receive data bits 15:0.
- R7: Status bit 1 (busy) is high from the cycle after a command write until the frame ends. Receive data holds the new value once busy reads 0.
- R8: A command write that arrives while busy starts no frame. Each accepted read or write produces exactly one frame.
- R9: Command bit 0 (scan) repeats read frames with no end while it stays set, and busy stays high. Status bit 2 (invalid) is set by the scan command and cleared when the first scan frame completes. Writing 0 to the command register stops the scan after the current frame.
- R10: Status bit 0 (link fail) equals the inverse of bit 2 of the most recently scanned value.
- R11: Command bit 2 (write) takes priority over bit 1 (read), which takes priority over bit 0 (scan).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register word index |
| wdata_i | input | 32 | Register write data |
| rdata_o | output | 32 | Register read data (combinational on addr_i) |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe_o | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input value |

## Verification
A corrupted bit or preamble counter shows up within a single frame, as a wrong frame length, a shifted field or a misplaced output-enable window on the line. A lost or stuck pending request shows as busy that never clears, or as a frame that is missing or duplicated. The bench counts frames to catch both. A wrong sampling point shows as wrong receive data when busy falls. Scan bookkeeping errors show in the invalid and link-fail bits within one or two scan frames of a change in the PHY's reply.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  typedef enum logic [1:0] {OP_NONE, OP_SCAN, OP_READ, OP_WRITE} mdio_op_e;

  localparam logic [2:0] REG_MODE = 3'd0;
  localparam logic [2:0] REG_CMD  = 3'd1;
  localparam logic [2:0] REG_ADDR = 3'd2;
  localparam logic [2:0] REG_TXD  = 3'd3;
  localparam logic [2:0] REG_RXD  = 3'd4;
  localparam logic [2:0] REG_STAT = 3'd5;
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int unsigned CW = 7
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] half_i,
  output logic          mdc_o,
  output logic          rise_o,
  output logic          fall_o
);
  logic [CW-1:0] cnt_q, lim;
  logic          mdc_q, tick;

  assign lim    = (half_i == '0) ? CW'(1) : half_i;
  assign tick   = (cnt_q >= lim - CW'(1));
  assign rise_o = tick & ~mdc_q;
  assign fall_o = tick & mdc_q;
  assign mdc_o  = mdc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (tick) begin
      cnt_q <= '0;
      mdc_q <= ~mdc_q;
    end else begin
      cnt_q <= cnt_q + CW'(1);
    end
  end

  a_r2_rise_lands_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> mdc_o);
  a_r2_fall_lands_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |=> !mdc_o);
endmodule

// File: rtl/mdio_engine.sv
module mdio_engine
  import mdio_pkg::*;
#(
  parameter int unsigned AW  = 5,
  parameter int unsigned DW  = 16,
  parameter int unsigned PRE = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rise_i,
  input  logic          fall_i,
  input  logic          go_i,
  input  mdio_op_e      op_i,
  input  logic          scan_en_i,
  input  logic          nopre_i,
  input  logic [AW-1:0] phy_i,
  input  logic [AW-1:0] reg_i,
  input  logic [DW-1:0] data_i,
  input  logic          mdio_i,
  output logic          mdio_o,
  output logic          mdio_oe_o,
  output logic          busy_o,
  output logic          done_o,
  output mdio_op_e      done_op_o,
  output logic [DW-1:0] rdata_o
);
  localparam int unsigned HW = 4 + 2 * AW;       // start, opcode, addresses
  localparam int unsigned FW = HW + 2 + DW;      // frame without preamble
  localparam int unsigned BW = $clog2(FW);
  localparam int unsigned PW = $clog2(PRE + 1);

  logic          pend_q, act_q;
  mdio_op_e      op_q;
  logic [FW-1:0] fr_q;
  logic [BW-1:0] bit_q;
  logic [PW-1:0] pre_left_q;
  logic [DW-1:0] sh_q;
  logic          in_pre, is_wr;
  logic [FW-1:0] fr_new;

  assign in_pre    = (pre_left_q != '0);
  assign is_wr     = (op_q == OP_WRITE);
  assign fr_new    = {2'b01, is_wr ? 2'b01 : 2'b10, phy_i, reg_i,
                      is_wr ? 2'b10 : 2'b00, is_wr ? data_i : {DW{1'b0}}};
  assign done_o    = fall_i & act_q & ~in_pre & (bit_q == BW'(FW - 1));
  assign busy_o    = pend_q | act_q;
  assign mdio_oe_o = act_q & (in_pre | is_wr | (bit_q < BW'(HW)));
  assign mdio_o    = act_q & (in_pre | fr_q[FW-1]);
  assign done_op_o = op_q;
  assign rdata_o   = sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q     <= 1'b0;
      act_q      <= 1'b0;
      op_q       <= OP_NONE;
      fr_q       <= '0;
      bit_q      <= '0;
      pre_left_q <= '0;
      sh_q       <= '0;
    end else begin
      if (go_i) begin
        pend_q <= 1'b1;
        op_q   <= op_i;
      end
      if (fall_i) begin
        if (!act_q && pend_q) begin
          act_q      <= 1'b1;
          pend_q     <= 1'b0;
          pre_left_q <= nopre_i ? '0 : PW'(PRE);
          bit_q      <= '0;
          fr_q       <= fr_new;
        end else if (act_q) begin
          if (in_pre) begin
            pre_left_q <= pre_left_q - PW'(1);
          end else if (bit_q == BW'(FW - 1)) begin
            act_q <= 1'b0;
            if (op_q == OP_SCAN && scan_en_i) pend_q <= 1'b1;  // scan re-arm
          end else begin
            bit_q <= bit_q + BW'(1);
            fr_q  <= {fr_q[FW-2:0], 1'b0};
          end
        end
      end
      if (rise_i && act_q && !in_pre && !is_wr && bit_q >= BW'(HW + 2))
        sh_q <= {sh_q[DW-2:0], mdio_i};
    end
  end

  a_r6_line_moves_on_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fall_i |=> $stable({mdio_o, mdio_oe_o}));
  a_r7_busy_until_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o) |=> busy_o);
  a_r8_op_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o) |=> $stable(op_q));
  a_r1_idle_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mdio_oe_o);
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter logic [7:0] DIV_RST = 8'd100,
  parameter int unsigned AW     = 5,
  parameter int unsigned DW     = 16
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        we_i,
  input  logic [2:0]  addr_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  output logic        mdc_o,
  output logic        mdio_o,
  output logic        mdio_oe_o,
  input  logic        mdio_i
);
  logic [7:0]    div_q;
  logic          nopre_q, lfail_q, inval_q;
  logic [2:0]    cmd_q;
  logic [AW-1:0] phy_q, regad_q;
  logic [DW-1:0] txd_q, rxd_q, eng_rdata;
  logic          rise, fall, busy, done, go;
  mdio_op_e      go_op, done_op;

  assign go    = we_i && (addr_i == REG_CMD) && !busy && (wdata_i[2:0] != 3'b000);
  assign go_op = wdata_i[2] ? OP_WRITE : (wdata_i[1] ? OP_READ : OP_SCAN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q   <= DIV_RST;
      nopre_q <= 1'b0;
      cmd_q   <= '0;
      phy_q   <= '0;
      regad_q <= '0;
      txd_q   <= '0;
      rxd_q   <= '0;
      lfail_q <= 1'b0;
      inval_q <= 1'b0;
    end else begin
      if (we_i) begin
        unique case (addr_i)
          REG_MODE: {nopre_q, div_q} <= wdata_i[8:0];
          REG_CMD:  cmd_q <= wdata_i[2:0];
          REG_ADDR: begin
            phy_q   <= wdata_i[AW-1:0];
            regad_q <= wdata_i[8+AW-1:8];
          end
          REG_TXD:  txd_q <= wdata_i[DW-1:0];
          default: ;
        endcase
      end
      if (go && go_op == OP_SCAN) inval_q <= 1'b1;
      if (done && done_op != OP_WRITE) rxd_q <= eng_rdata;
      if (done && done_op == OP_SCAN) begin
        inval_q <= 1'b0;
        lfail_q <= ~eng_rdata[2];
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      REG_MODE: rdata_o[8:0] = {nopre_q, div_q};
      REG_CMD:  rdata_o[2:0] = cmd_q;
      REG_ADDR: begin
        rdata_o[AW-1:0]     = phy_q;
        rdata_o[8+AW-1:8]   = regad_q;
      end
      REG_TXD:  rdata_o[DW-1:0] = txd_q;
      REG_RXD:  rdata_o[DW-1:0] = rxd_q;
      REG_STAT: rdata_o[2:0] = {inval_q, busy, lfail_q};
      default: ;
    endcase
  end

  mdio_clkgen #(.CW(7)) i_clkgen (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .half_i (div_q[7:1]),
    .mdc_o  (mdc_o),
    .rise_o (rise),
    .fall_o (fall)
  );

  mdio_engine #(.AW(AW), .DW(DW), .PRE(32)) i_engine (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rise_i    (rise),
    .fall_i    (fall),
    .go_i      (go),
    .op_i      (go_op),
    .scan_en_i (cmd_q[0]),
    .nopre_i   (nopre_q),
    .phy_i     (phy_q),
    .reg_i     (regad_q),
    .data_i    (txd_q),
    .mdio_i    (mdio_i),
    .mdio_o    (mdio_o),
    .mdio_oe_o (mdio_oe_o),
    .busy_o    (busy),
    .done_o    (done),
    .done_op_o (done_op),
    .rdata_o   (eng_rdata)
  );

  a_r9_invalid_only_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inval_q |-> busy);
  a_r8_no_go_when_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == REG_CMD && busy) |=> $stable(inval_q) || done);
  a_r10_lfail_on_scan_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done && done_op == OP_SCAN) |=> $stable(lfail_q));
endmodule

// File: tb/test_mdio_master.sv
module test_mdio_master;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        mdc, mdio_o, mdio_oe;
  logic        mdio_in = 1'b1;

  int total = 0, bad = 0, cyc = 0;

  // PHY responder state
  int          ones = 0, rcnt = 0, pre_last = -1, frames = 0;
  logic        in_frame = 1'b0, rd_frame = 1'b0, link_bit = 1'b1;
  logic [31:0] sh = '0, omask = '0, fr_last = '0, om_last = '0;
  logic [15:0] resp = '0;

  mdio_master i_mdio_master (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .mdc_o(mdc), .mdio_o(mdio_o), .mdio_oe_o(mdio_oe), .mdio_i(mdio_in)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      total++; bad++;
      $display("FAIL R7 watchdog act=hung exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  function automatic logic [15:0] phy_val(input logic [4:0] p, input logic [4:0] r, input logic lk);
    if (r == 5'd1) return {8'hA5, 5'b0, lk, 2'b01};
    return {p, r, 6'h2B} ^ 16'h5A3C;
  endfunction

  always @(posedge mdc) begin
    if (!in_frame) begin
      if (mdio_oe && mdio_o) ones++;
      else if (mdio_oe && !mdio_o) begin
        in_frame = 1'b1; rcnt = 1; sh = '0; omask = 32'd1;
        pre_last = ones; ones = 0; rd_frame = 1'b0;
      end else ones = 0;
    end else begin
      sh    = {sh[30:0], mdio_oe ? mdio_o : mdio_in};
      omask = {omask[30:0], mdio_oe};
      rcnt++;
      if (rcnt == 14 && sh[11:10] == 2'b10) begin
        rd_frame = 1'b1;
        resp = phy_val(sh[9:5], sh[4:0], link_bit);
      end
      if (rcnt == 32) begin
        in_frame = 1'b0; rd_frame = 1'b0;
        fr_last = sh; om_last = omask; frames++;
      end
    end
  end

  always @(negedge mdc) begin
    if (in_frame && rd_frame && rcnt == 15) mdio_in = 1'b0;
    else if (in_frame && rd_frame && rcnt >= 16 && rcnt <= 31) mdio_in = resp[31-rcnt];
    else mdio_in = 1'b1;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] st;
    do rd(3'd5, st); while (st[1]);
  endtask

  task automatic do_op(input bit isw, input logic [4:0] p, input logic [4:0] r,
                       input logic [15:0] d, input bit nop, input logic [7:0] dv);
    logic [31:0] st, v, efr;
    int f0;
    wr(3'd0, {23'b0, nop, dv});
    wr(3'd2, {19'b0, r, 3'b0, p});
    wr(3'd3, {16'b0, d});
    f0 = frames;
    wr(3'd1, isw ? 32'd4 : 32'd2);
    rd(3'd5, st);
    chk("R7 busy after command", {31'b0, st[1]}, 32'd1);
    wait_idle();
    chk("R8 one frame per command", frames, f0 + 1);
    efr = {2'b01, isw ? 2'b01 : 2'b10, p, r, 2'b10, isw ? d : phy_val(p, r, link_bit)};
    chk(isw ? "R5 write frame" : "R4 read frame", fr_last, efr);
    chk(isw ? "R5 oe window" : "R4 oe window", om_last, isw ? 32'hFFFF_FFFF : 32'hFFFC_0000);
    chk("R3 preamble length", pre_last, nop ? 32'd0 : 32'd32);
    if (!isw) begin
      rd(3'd4, v);
      chk("R6 R7 read data", v, {16'b0, phy_val(p, r, link_bit)});
    end
  endtask

  task automatic chk_period(input logic [7:0] dv, input int exp);
    int c0;
    wr(3'd0, {24'b0, dv});
    @(posedge mdc); @(posedge mdc);
    c0 = cyc;
    @(posedge mdc);
    chk("R2 mdc period", cyc - c0, exp);
  endtask

  initial begin
    logic [31:0] v;
    int f0, seed;
    seed = $urandom(32'd2024);
    repeat (5) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(3'd0, v); chk("R1 mode reset", v, 32'h64);
    rd(3'd1, v); chk("R1 command reset", v, 32'h0);
    rd(3'd5, v); chk("R1 status reset", v, 32'h0);
    rd(3'd4, v); chk("R1 rx reset", v, 32'h0);
    chk("R1 line released", {31'b0, mdio_oe}, 32'd0);

    // R2 divider, even only
    chk_period(8'd6, 6);
    chk_period(8'd7, 6);
    chk_period(8'd0, 2);
    chk_period(8'd1, 2);
    chk_period(8'd10, 10);

    // directed frames, R3 with and without preamble
    do_op(1'b0, 5'h1F, 5'h00, 16'h0, 1'b0, 8'd4);
    do_op(1'b1, 5'h00, 5'h1F, 16'hFFFF, 1'b1, 8'd4);
    do_op(1'b1, 5'h15, 5'h0A, 16'h8001, 1'b0, 8'd2);
    do_op(1'b0, 5'h0A, 5'h15, 16'h0, 1'b1, 8'd3);

    // random mix
    for (int i = 0; i < 10; i++) begin
      do_op(1'($urandom % 2), 5'($urandom), 5'($urandom), 16'($urandom),
            1'($urandom % 2), 8'(2 + $urandom % 8));
    end

    // R8: command while busy is ignored
    wr(3'd0, 32'd20);
    wr(3'd2, {19'b0, 5'd3, 3'b0, 5'd4});
    f0 = frames;
    wr(3'd1, 32'd2);
    wr(3'd1, 32'd4);
    wait_idle();
    repeat (400) @(negedge clk);
    chk("R8 busy command ignored count", frames, f0 + 1);
    chk("R8 busy command ignored op", {30'b0, fr_last[29:28]}, 32'd2);

    // R11 priority
    wr(3'd0, 32'd4);
    f0 = frames;
    wr(3'd1, 32'd7);
    wait_idle();
    chk("R11 write wins", {30'b0, fr_last[29:28]}, 32'd1);
    wr(3'd1, 32'd3);
    wait_idle();
    chk("R11 read over scan", {30'b0, fr_last[29:28]}, 32'd2);
    rd(3'd5, v); chk("R11 no scan started", v, 32'h0);
    chk("R11 frame count", frames, f0 + 2);

    // R9 R10 scan
    link_bit = 1'b1;
    wr(3'd2, {19'b0, 5'd1, 3'b0, 5'd7});
    f0 = frames;
    wr(3'd1, 32'd1);
    rd(3'd5, v); chk("R9 invalid and busy at scan start", v & 32'h6, 32'h6);
    while (frames < f0 + 1) @(negedge clk);
    repeat (12) @(negedge clk);
    rd(3'd5, v); chk("R9 R10 status after first scan", v, 32'h2);
    rd(3'd4, v); chk("R9 scan data", v, {16'b0, phy_val(5'd7, 5'd1, 1'b1)});
    link_bit = 1'b0;
    f0 = frames;
    while (frames < f0 + 2) @(negedge clk);
    repeat (12) @(negedge clk);
    rd(3'd5, v); chk("R10 link fail follows bit 2", v, 32'h3);
    rd(3'd4, v); chk("R9 scan data refresh", v, {16'b0, phy_val(5'd7, 5'd1, 1'b0)});
    wr(3'd1, 32'd0);
    wait_idle();
    f0 = frames;
    repeat (400) @(negedge clk);
    chk("R9 scan stops", frames, f0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule